// File: doc/BRIEF.md
# Word-Addressed Serial Port with Single-Byte Receive Holding

This block attaches a byte-wide asynchronous serial line to a 32-bit register bus. A bus master sends a character by writing the transmit register. It polls the status word for two flags, and it collects an incoming character from a one-byte holding register. The window covers six word slots, which are indices 0 to 5 (byte offsets 0x00 to 0x14). Three slots are decoded. The others read as zero and swallow writes.

The bus port is a valid/ready channel whose ready is tied high, so every request is taken in the cycle it is offered. A read answers one cycle later with a single-cycle response pulse. There is no response back-pressure, so the master must sample the response in that cycle. Back-pressure on the serial side lives in the holding register. Until software drains it, any newly completed frame is thrown away and a sticky overrun pin is raised. The transmitter takes no new character while it is busy, and a write made then is lost. Software should poll the transmit-ready flag before it writes.

The line format is fixed: one start bit, eight data bits least significant first, no parity and one stop bit. Each bit lasts `OVS*CLK_DIV` clock cycles. The receiver passes the input through two flip-flops and samples each bit at its midpoint.

Top module: `word_uart`

## Requirements
- R1: After reset the status word reads 0x2, the receive register reads 0, `uart_txd` is high and `rx_overrun` is low.
- R2: Word index 0 is transmit data (write), index 1 is receive data (read) and index 5 is status. A read of any other index, including 6 and 7 beyond the window, returns 0, and a write there changes no state and no output.
- R3: In the status word, bit 0 is receive-ready and bit 1 is transmit-ready, and bits 31:2 read as 0. Reading the status word leaves both flags unchanged.
- R4: A read of index 1 returns the held byte in bits 7:0 with bits 31:8 zero, and the flag is clear from the next cycle on.
- R5: Writes to the status word are discarded; the flags and the held byte keep their values.
- R6: A received frame is accepted only while receive-ready is clear. Its byte is then latched, and receive-ready is set.
- R7: While receive-ready is set, a completed frame is discarded, the held byte is kept, and `rx_overrun` rises and stays high until reset.
- R8: A frame whose stop bit samples low is discarded without setting receive-ready or overrun.
- R9: A write to index 0 while transmit-ready is set sends `bus_wdata[7:0]` as a frame with start bit low, data LSB first and stop bit high, each bit `OVS*CLK_DIV` cycles long. Transmit-ready is clear from the write until the stop bit ends, and the line is high whenever the transmitter is idle.
- R10: A write to index 0 while transmit-ready is clear is dropped; the frame in progress is unaffected and no further frame follows.
- R11: `bus_ready` is always high. `rsp_valid` pulses for exactly one cycle, in the cycle after each accepted read and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request ready, constant high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_index | input | 3 | Word index (byte offset divided by four) |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one-cycle pulse |
| rsp_rdata | output | 32 | Read response data |
| uart_txd | output | 1 | Serial transmit line, idle high |
| uart_rxd | input | 1 | Serial receive line, asynchronous |
| rx_overrun | output | 1 | Sticky: a frame was discarded because the holding register was full |

## Verification
The assertions assume that `bus_valid` is low while reset is applied and that each request is held for exactly one cycle. The bench drives every request from a task that raises valid for one clock and drops it again. The assertions also assume that serial frames on `uart_rxd` keep the nominal bit time. The bench drives each bit for exactly `OVS*CLK_DIV` cycles with `CLK_DIV` set to 1. It sends frames back to back, or with idle gaps, only after the previous stop bit is complete.

// File: rtl/wbu_pkg.sv
package wbu_pkg;
  localparam int unsigned IDX_W = 3;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t IDX_TXDATA = 3'd0;
  localparam idx_t IDX_RXDATA = 3'd1;
  localparam idx_t IDX_STATUS = 3'd5;

  localparam int unsigned FLAG_RX_POS = 0;
  localparam int unsigned FLAG_TX_POS = 1;
  localparam int unsigned BYTE_W      = 8;

  typedef enum logic [1:0] {
    LN_IDLE,
    LN_START,
    LN_DATA,
    LN_STOP
  } line_st_e;
endpackage

// File: rtl/wbu_tick.sv
module wbu_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every_cycle
      assign tick = ~restart;
    end else begin : g_counted
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt <= '0;
        else if (restart || cnt == LAST)  cnt <= '0;
        else                              cnt <= cnt + 1'b1;
      end
      assign tick = !restart && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/wbu_tx.sv
module wbu_tx
  import wbu_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned OVS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [BYTE_W-1:0] load_data,
  output logic              load_ready,
  output logic              txd
);
  localparam int unsigned OW = $clog2(OVS);
  localparam logic [OW-1:0] OVS_LAST = OW'(OVS - 1);
  localparam int unsigned BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_W - 1);

  line_st_e          state;
  logic [OW-1:0]     ovs;
  logic [BW-1:0]     bit_idx;
  logic [BYTE_W-1:0] shreg;
  logic              tick;

  wbu_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(state == LN_IDLE), .tick(tick)
  );

  assign load_ready = (state == LN_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= LN_IDLE;
      txd     <= 1'b1;
      ovs     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
    end else if (state == LN_IDLE) begin
      if (load_valid) begin
        shreg <= load_data;
        txd   <= 1'b0;
        ovs   <= '0;
        state <= LN_START;
      end
    end else if (tick) begin
      if (ovs != OVS_LAST) begin
        ovs <= ovs + 1'b1;
      end else begin
        ovs <= '0;
        unique case (state)
          LN_START: begin
            txd     <= shreg[0];
            shreg   <= shreg >> 1;
            bit_idx <= '0;
            state   <= LN_DATA;
          end
          LN_DATA: begin
            if (bit_idx == BIT_LAST) begin
              txd   <= 1'b1;
              state <= LN_STOP;
            end else begin
              txd     <= shreg[0];
              shreg   <= shreg >> 1;
              bit_idx <= bit_idx + 1'b1;
            end
          end
          default: state <= LN_IDLE;
        endcase
      end
    end
  end

  a_r9_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LN_IDLE) |-> txd);
  a_r9_start_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && load_ready) |=> (!txd && !load_ready));
endmodule

// File: rtl/wbu_rx.sv
module wbu_rx
  import wbu_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned OVS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_async,
  output logic              frm_valid,
  output logic [BYTE_W-1:0] frm_data
);
  localparam int unsigned OW = $clog2(OVS);
  localparam logic [OW-1:0] OVS_LAST = OW'(OVS - 1);
  localparam logic [OW-1:0] OVS_MID  = OW'(OVS / 2 - 1);
  localparam int unsigned BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_W - 1);

  logic              sync1, rxd;
  line_st_e          state;
  logic [OW-1:0]     ovs;
  logic [BW-1:0]     bit_idx;
  logic [BYTE_W-1:0] shreg;
  logic              tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      rxd   <= 1'b1;
    end else begin
      sync1 <= rxd_async;
      rxd   <= sync1;
    end
  end

  wbu_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(state == LN_IDLE), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= LN_IDLE;
      ovs       <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      frm_valid <= 1'b0;
      frm_data  <= '0;
    end else begin
      frm_valid <= 1'b0;
      unique case (state)
        LN_IDLE: begin
          if (!rxd) begin
            ovs   <= '0;
            state <= LN_START;
          end
        end
        LN_START: begin
          if (tick) begin
            if (ovs == OVS_MID) begin
              ovs     <= '0;
              bit_idx <= '0;
              state   <= rxd ? LN_IDLE : LN_DATA;
            end else begin
              ovs <= ovs + 1'b1;
            end
          end
        end
        LN_DATA: begin
          if (tick) begin
            if (ovs == OVS_LAST) begin
              ovs   <= '0;
              shreg <= {rxd, shreg[BYTE_W-1:1]};
              if (bit_idx == BIT_LAST) state <= LN_STOP;
              else                     bit_idx <= bit_idx + 1'b1;
            end else begin
              ovs <= ovs + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (ovs == OVS_LAST) begin
              frm_valid <= rxd;
              frm_data  <= shreg;
              state     <= LN_IDLE;
            end else begin
              ovs <= ovs + 1'b1;
            end
          end
        end
      endcase
    end
  end

  a_r6_frame_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);
  a_r6_frame_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> $past(state == LN_STOP));
endmodule

// File: rtl/word_uart.sv
module word_uart
  import wbu_pkg::*;
#(
  parameter int unsigned CLK_DIV = 27,
  parameter int unsigned OVS     = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [IDX_W-1:0]  bus_index,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              uart_txd,
  input  logic              uart_rxd,
  output logic              rx_overrun
);
  logic              acc, rd_acc, tx_load, rd_rxdata;
  logic              tx_rdy, rx_rdy;
  logic              frm_valid;
  logic [BYTE_W-1:0] frm_data, hold;
  logic [DATA_W-1:0] status, rdata_next;
  logic              wdata_unused;

  assign bus_ready    = 1'b1;
  assign acc          = bus_valid;
  assign rd_acc       = acc && !bus_write;
  assign tx_load      = acc && bus_write && (bus_index == IDX_TXDATA);
  assign rd_rxdata    = rd_acc && (bus_index == IDX_RXDATA);
  assign wdata_unused = ^bus_wdata[DATA_W-1:BYTE_W];

  wbu_tx #(.CLK_DIV(CLK_DIV), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load_valid(tx_load), .load_data(bus_wdata[BYTE_W-1:0]),
    .load_ready(tx_rdy), .txd(uart_txd)
  );

  wbu_rx #(.CLK_DIV(CLK_DIV), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd_async(uart_rxd),
    .frm_valid(frm_valid), .frm_data(frm_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rdy     <= 1'b0;
      hold       <= '0;
      rx_overrun <= 1'b0;
    end else begin
      if (frm_valid && !rx_rdy) begin
        rx_rdy <= 1'b1;
        hold   <= frm_data;
      end else if (rd_rxdata) begin
        rx_rdy <= 1'b0;
      end
      if (frm_valid && rx_rdy) rx_overrun <= 1'b1;
    end
  end

  always_comb begin
    status              = '0;
    status[FLAG_RX_POS] = rx_rdy;
    status[FLAG_TX_POS] = tx_rdy;
    unique case (bus_index)
      IDX_RXDATA: rdata_next = {{(DATA_W-BYTE_W){1'b0}}, hold};
      IDX_STATUS: rdata_next = status;
      default:    rdata_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_rdata <= rdata_next;
    end
  end

  a_r4_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxdata && rx_rdy) |=> !rx_rdy);
  a_r7_hold_kept_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rdy |=> $stable(hold));
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> rx_overrun);
  a_r11_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_valid && !bus_write));
  a_r11_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready);
endmodule

// File: tb/word_uart_bench.sv
module word_uart_bench;
  localparam int unsigned DIV = 1;
  localparam int unsigned OVS = 16;
  localparam int unsigned BIT = DIV * OVS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_index = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        uart_txd;
  logic        uart_rxd = 1'b1;
  logic        rx_overrun;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  word_uart #(.CLK_DIV(DIV), .OVS(OVS)) u_word_uart (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_index(bus_index), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .uart_txd(uart_txd),
    .uart_rxd(uart_rxd), .rx_overrun(rx_overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_index = idx; bus_wdata = d;
    chk("R11 ready", {31'b0, bus_ready}, 32'd1);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_index = idx;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R11 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
    @(negedge clk);
    chk("R11 single pulse", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] idx, input logic [31:0] exp);
    logic [31:0] d;
    rd(idx, d);
    chk(req, d, exp);
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    @(negedge clk);
    uart_rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      uart_rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    uart_rxd = stop;
    repeat (BIT) @(negedge clk);
    uart_rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic recv(output logic [7:0] b);
    int w = 0;
    b = '0;
    while (uart_txd === 1'b1 && w < 1000) begin
      @(negedge clk);
      w++;
    end
    repeat (BIT / 2) @(negedge clk);
    chk("R9 start bit", {31'b0, uart_txd}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      b[i] = uart_txd;
    end
    repeat (BIT) @(negedge clk);
    chk("R9 stop bit", {31'b0, uart_txd}, 32'd1);
  endtask

  initial begin
    logic [7:0]  got;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txd idle", {31'b0, uart_txd}, 32'd1);
    chk("R1 overrun", {31'b0, rx_overrun}, 32'd0);
    rd_chk("R1 status", 3'd5, 32'h2);
    rd_chk("R1 rx data", 3'd1, 32'h0);
    rd_chk("R3 status after empty read", 3'd5, 32'h2);

    // R2 unknown indices
    for (int k = 2; k < 8; k++) begin
      if (k == 5) continue;
      rd_chk("R2 unknown read", 3'(k), 32'h0);
      wr(3'(k), 32'hFFFF_FFFF);
    end
    repeat (20) @(negedge clk);
    chk("R2 txd untouched", {31'b0, uart_txd}, 32'd1);
    rd_chk("R2 status untouched", 3'd5, 32'h2);

    // R6 R4 R3: receive every byte value
    for (int v = 0; v < 256; v++) begin
      send(8'(v), 1'b1);
      rd_chk("R6 R3 status full", 3'd5, 32'h3);
      rd_chk("R4 rx byte", 3'd1, {24'b0, 8'(v)});
      rd_chk("R4 ready cleared", 3'd5, 32'h2);
    end

    // R5 status writes discarded
    send(8'hC3, 1'b1);
    wr(3'd5, 32'h0);
    rd_chk("R5 after write 0", 3'd5, 32'h3);
    wr(3'd5, 32'hFFFF_FFFF);
    rd_chk("R5 after write ones", 3'd5, 32'h3);
    rd_chk("R5 byte intact", 3'd1, 32'hC3);
    rd_chk("R5 then cleared", 3'd5, 32'h2);

    // R8 framing error
    send(8'h5A, 1'b0);
    repeat (BIT) @(negedge clk);
    rd_chk("R8 no accept", 3'd5, 32'h2);
    chk("R8 no overrun", {31'b0, rx_overrun}, 32'd0);

    // R9 transmit every byte value
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, {24'hABCDEF, 8'(v)});
      if (v == 0) rd_chk("R9 tx busy", 3'd5, 32'h0);
      recv(got);
      chk("R9 tx byte", {24'b0, got}, {24'b0, 8'(v)});
      repeat (BIT / 2 + 1) @(negedge clk);
      rd_chk("R9 tx ready again", 3'd5, 32'h2);
    end

    // R10 write while busy dropped
    wr(3'd0, 32'h96);
    wr(3'd0, 32'h69);
    recv(got);
    chk("R10 first frame kept", {24'b0, got}, 32'h96);
    begin
      logic seen_low = 1'b0;
      for (int c = 0; c < 12 * BIT; c++) begin
        @(negedge clk);
        if (uart_txd !== 1'b1) seen_low = 1'b1;
      end
      chk("R10 no second frame", {31'b0, seen_low}, 32'd0);
    end

    // R7 overrun
    send(8'h11, 1'b1);
    send(8'h22, 1'b1);
    chk("R7 overrun set", {31'b0, rx_overrun}, 32'd1);
    rd_chk("R7 held byte kept", 3'd1, 32'h11);
    rd_chk("R7 ready cleared", 3'd5, 32'h2);
    send(8'h33, 1'b1);
    rd_chk("R6 accept after drain", 3'd1, 32'h33);
    chk("R7 overrun sticky", {31'b0, rx_overrun}, 32'd1);
    rd(3'd5, d);
    chk("R3 upper bits zero", d & 32'hFFFF_FFFC, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule